// File: doc/BRIEF.md
# Byte-Wise SECDED Guard with Error Event Capture

This block sits between a processor-side memory port and the storage arrays of an instruction memory and a data memory. On the write side it turns each data byte into a 13-bit codeword by adding five check bits, and the caller stores those bits next to the data. On the read side it takes the stored data and check bits and recomputes the code for every byte independently. It repairs any single flipped bit in a byte and reports a byte with two flipped bits as uncorrectable. The read path is purely combinational, so corrected data is available in the same cycle as the raw read.

Every error found on a valid read is logged in a small sticky event register. The register keeps one flag per error class for each of the two memories. A single level interrupt stays high while any flag is set. Software clears the log by writing zero to it. A hardware event that arrives in the same cycle as that write is still kept.

Top module: `edc_guard`

## Requirements
- R1: Byte i of `wr_data` (bits 8i+7..8i) gets its check field at `wr_check` bits 5i+4..5i. Data bit j sits at Hamming position 3,5,6,7,9,10,11,12 for j = 0..7. Check bit k (k = 0..3) is the XOR of the data bits whose position has bit k set. Check bit 4 is the XOR of the byte and check bits 0..3.
- R2: When every byte's check field matches its data, `rd_fixed` equals `rd_data` in the same cycle and no event flag is set.
- R3: When exactly one of the 13 stored bits of a byte is flipped (data or check), `rd_fixed` returns the original byte in the same cycle.
- R4: When exactly two of a byte's 13 stored bits are flipped, that byte passes to `rd_fixed` uncorrected, equal to the received data.
- R5: Event flag layout is bit 0 = instruction memory 1-bit, bit 1 = instruction memory 2-bit, bit 2 = data memory 1-bit, bit 3 = data memory 2-bit. `rd_src` = 0 selects the instruction memory and 1 the data memory. A flag is set one clock after a valid read containing that class of error.
- R6: Flags are sticky. They OR over all bytes of a read and over successive reads. A read with `rd_valid` low sets no flag.
- R7: A write with `evt_we` high and `evt_wdata` zero clears all flags on the next edge. A write with nonzero data has no effect.
- R8: When a valid read with an error arrives in the same cycle as a clearing write, the flag for that error is set after the edge.
- R9: `irq` is high exactly while any event flag is set.
- R10: After reset all flags are zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data | input | 32 | Data to be stored |
| wr_check | output | 40 | Check bits for `wr_data`, 5 per byte |
| rd_valid | input | 1 | A read is presented this cycle |
| rd_src | input | 1 | 0 = instruction memory, 1 = data memory |
| rd_data | input | 32 | Data read from storage |
| rd_check | input | 40 | Check bits read from storage |
| rd_fixed | output | 32 | Corrected read data |
| evt_we | input | 1 | Event register write strobe |
| evt_wdata | input | 4 | Event register write data (only zero acts) |
| evt_q | output | 4 | Event flags |
| irq | output | 1 | Level interrupt, any flag set |

## Verification
The bench builds the block with its default of four bytes per word. This width is enough to place a correctable error and an uncorrectable error in different bytes of one read. The bench then checks that both classes are logged together. With four bytes, every one of the 13 flip positions per byte can be exercised on every byte lane through seeded random injection. The same width also lets the bench check that lanes without an error pass through untouched beside a lane that is being repaired.

// File: rtl/edc_pkg.sv
package edc_pkg;
  localparam int CHK_W = 5;
  localparam int EVT_W = 4;

  // Hamming position of data bit j (skips the powers of two)
  function automatic logic [3:0] data_pos(input int j);
    logic [3:0] p;
    case (j)
      0: p = 4'd3;
      1: p = 4'd5;
      2: p = 4'd6;
      3: p = 4'd7;
      4: p = 4'd9;
      5: p = 4'd10;
      6: p = 4'd11;
      default: p = 4'd12;
    endcase
    return p;
  endfunction

  function automatic logic [CHK_W-1:0] enc_byte(input logic [7:0] d);
    logic [CHK_W-1:0] c;
    logic [3:0] pos;
    c = '0;
    for (int j = 0; j < 8; j++) begin
      pos = data_pos(j);
      for (int k = 0; k < 4; k++)
        if (pos[k]) c[k] = c[k] ^ d[j];
    end
    c[4] = (^d) ^ (^c[3:0]);
    return c;
  endfunction
endpackage

// File: rtl/edc_byte_enc.sv
module edc_byte_enc
  import edc_pkg::*;
(
  input  logic [7:0]       din,
  output logic [CHK_W-1:0] chk
);
  always_comb chk = enc_byte(din);
endmodule

// File: rtl/edc_byte_dec.sv
module edc_byte_dec
  import edc_pkg::*;
(
  input  logic [7:0]       din,
  input  logic [CHK_W-1:0] chk,
  output logic [7:0]       dout,
  output logic             err_one,
  output logic             err_two
);
  logic [CHK_W-1:0] recalc;
  logic [3:0]       synd;
  logic             par_odd;

  always_comb begin
    recalc  = enc_byte(din);
    synd    = recalc[3:0] ^ chk[3:0];
    par_odd = (^din) ^ (^chk);
    err_one = par_odd && (synd <= 4'd12);
    err_two = (!par_odd && (synd != 4'd0)) || (par_odd && (synd > 4'd12));
    for (int j = 0; j < 8; j++)
      dout[j] = din[j] ^ (err_one && (synd == data_pos(j)));
  end
endmodule

// File: rtl/edc_event_reg.sv
module edc_event_reg
  import edc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] hits,
  input  logic             we,
  input  logic [EVT_W-1:0] wdata,
  output logic [EVT_W-1:0] q,
  output logic             irq
);
  logic [EVT_W-1:0] q_n;
  logic             en;

  always_comb begin
    en  = we | (|hits);
    q_n = q;
    if (we && (wdata == '0)) q_n = '0;
    q_n = q_n | hits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= q_n;
  end

  always_comb irq = |q;
endmodule

// File: rtl/edc_guard.sv
module edc_guard
  import edc_pkg::*;
#(
  parameter int BYTES = 4,
  localparam int DW = 8 * BYTES,
  localparam int CW = CHK_W * BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    wr_data,
  output logic [CW-1:0]    wr_check,
  input  logic             rd_valid,
  input  logic             rd_src,
  input  logic [DW-1:0]    rd_data,
  input  logic [CW-1:0]    rd_check,
  output logic [DW-1:0]    rd_fixed,
  input  logic             evt_we,
  input  logic [EVT_W-1:0] evt_wdata,
  output logic [EVT_W-1:0] evt_q,
  output logic             irq
);
  logic [BYTES-1:0] one_v, two_v;
  logic             any_one, any_two;
  logic [EVT_W-1:0] hits;

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    edc_byte_enc u_enc (
      .din (wr_data[8*b +: 8]),
      .chk (wr_check[CHK_W*b +: CHK_W])
    );
    edc_byte_dec u_dec (
      .din     (rd_data[8*b +: 8]),
      .chk     (rd_check[CHK_W*b +: CHK_W]),
      .dout    (rd_fixed[8*b +: 8]),
      .err_one (one_v[b]),
      .err_two (two_v[b])
    );
  end

  always_comb begin
    any_one = |one_v;
    any_two = |two_v;
    hits[0] = rd_valid && !rd_src && any_one;
    hits[1] = rd_valid && !rd_src && any_two;
    hits[2] = rd_valid &&  rd_src && any_one;
    hits[3] = rd_valid &&  rd_src && any_two;
  end

  edc_event_reg u_evt (
    .clk   (clk),
    .rst_n (rst_n),
    .hits  (hits),
    .we    (evt_we),
    .wdata (evt_wdata),
    .q     (evt_q),
    .irq   (irq)
  );
endmodule

// File: rtl/edc_guard_chk.sv
module edc_guard_chk
  import edc_pkg::*;
#(
  parameter int BYTES = 4,
  localparam int DW = 8 * BYTES,
  localparam int CW = CHK_W * BYTES
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DW-1:0]    wr_data,
  input logic [CW-1:0]    wr_check,
  input logic             rd_valid,
  input logic             rd_src,
  input logic [DW-1:0]    rd_data,
  input logic [CW-1:0]    rd_check,
  input logic [DW-1:0]    rd_fixed,
  input logic             evt_we,
  input logic [EVT_W-1:0] evt_wdata,
  input logic [EVT_W-1:0] evt_q,
  input logic             irq
);
  logic clear_req;
  assign clear_req = evt_we && (evt_wdata == '0);

  // R2: a read whose check bits match its data leaves the data untouched
  p_clean_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_check == wr_check && rd_data == wr_data) |-> (rd_fixed == rd_data));

  // R6: flags never drop without a clearing write
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_req |=> ((evt_q & $past(evt_q)) == $past(evt_q)));

  // R6: no read and no write leaves flags unchanged
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_valid && !evt_we) |=> $stable(evt_q));

  // R7: a clearing write with no read empties the register
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_req && !rd_valid) |=> (evt_q == '0));

  // R5: a flag for a memory only rises after a read of that memory
  p_src_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_valid || rd_src) |=> ((evt_q[1:0] & ~$past(evt_q[1:0])) == 2'b00));

  // R9: interrupt level follows flag contents
  p_irq_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (evt_q != '0));
endmodule

bind edc_guard edc_guard_chk #(.BYTES(BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_check(wr_check),
  .rd_valid(rd_valid), .rd_src(rd_src), .rd_data(rd_data),
  .rd_check(rd_check), .rd_fixed(rd_fixed), .evt_we(evt_we),
  .evt_wdata(evt_wdata), .evt_q(evt_q), .irq(irq)
);

// File: tb/tb_edc_guard.sv
module tb_edc_guard;
  localparam int BYTES = 4;
  localparam int DW = 8 * BYTES;
  localparam int CW = 5 * BYTES;

  logic          clk, rst_n;
  logic [DW-1:0] wr_data, rd_data, rd_fixed;
  logic [CW-1:0] wr_check, rd_check;
  logic          rd_valid, rd_src, evt_we, irq;
  logic [3:0]    evt_wdata, evt_q, exp_q;
  int            total, bad;
  bit            done;

  edc_guard #(.BYTES(BYTES)) dut (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_check(wr_check),
    .rd_valid(rd_valid), .rd_src(rd_src), .rd_data(rd_data),
    .rd_check(rd_check), .rd_fixed(rd_fixed), .evt_we(evt_we),
    .evt_wdata(evt_wdata), .evt_q(evt_q), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Code from R1, built from Hamming positions directly
  function automatic logic [4:0] ref_enc(input logic [7:0] d);
    logic [4:0] c;
    int         j;
    c = '0;
    j = 0;
    for (int pos = 1; pos <= 12; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        for (int k = 0; k < 4; k++)
          if (((pos >> k) & 1) == 1) c[k] = c[k] ^ d[j];
        j++;
      end
    end
    c[4] = (^d) ^ (^c[3:0]);
    return c;
  endfunction

  function automatic logic [CW-1:0] ref_word(input logic [DW-1:0] d);
    logic [CW-1:0] c;
    for (int b = 0; b < BYTES; b++) c[5*b +: 5] = ref_enc(d[8*b +: 8]);
    return c;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // flips[b] is a 13-bit mask {check[4:0], data[7:0]} for byte b
  task automatic do_read(input logic [DW-1:0] d, input logic [12:0] flips [BYTES],
                         input logic src, input logic valid, input string req);
    logic [CW-1:0] c;
    logic [DW-1:0] rx, exp_out;
    logic [3:0]    ev;
    int            n;
    c = ref_word(d);
    rx = d;
    exp_out = d;
    ev = '0;
    for (int b = 0; b < BYTES; b++) begin
      rx[8*b +: 8] = d[8*b +: 8] ^ flips[b][7:0];
      c[5*b +: 5]  = c[5*b +: 5] ^ flips[b][12:8];
      n = $countones(flips[b]);
      if (n == 1) ev[src ? 2 : 0] = 1'b1;
      if (n == 2) begin
        ev[src ? 3 : 1] = 1'b1;
        exp_out[8*b +: 8] = rx[8*b +: 8];
      end
    end
    @(negedge clk);
    rd_valid = valid; rd_src = src; rd_data = rx; rd_check = c;
    #2;
    check(req, rd_fixed, exp_out);
    if (valid) exp_q = exp_q | ev;
    @(negedge clk);
    rd_valid = 1'b0;
    #1;
    check({req, " flags R5"}, evt_q, exp_q);
    check("R9", irq, exp_q != 0);
  endtask

  task automatic evt_write(input logic [3:0] v);
    @(negedge clk);
    evt_we = 1'b1; evt_wdata = v;
    @(negedge clk);
    evt_we = 1'b0;
    if (v == 0) exp_q = '0;
    #1;
    check(v == 0 ? "R7 clear" : "R7 nonzero ignored", evt_q, exp_q);
    check("R9", irq, exp_q != 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [12:0] fl [BYTES];
    logic [DW-1:0] d;
    int p0, p1, b;
    total = 0; bad = 0; done = 0;
    void'($urandom(32'd2024));
    rst_n = 1'b0; wr_data = '0; rd_valid = 0; rd_src = 0; rd_data = '0;
    rd_check = '0; evt_we = 0; evt_wdata = '0; exp_q = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    check("R10 flags", evt_q, 4'h0);
    check("R10 irq", irq, 1'b0);

    // R1 encoding, random plus corners
    for (int i = 0; i < 24; i++) begin
      wr_data = (i == 0) ? '0 : (i == 1) ? '1 : $urandom;
      #1;
      check("R1 encode", wr_check, ref_word(wr_data));
    end

    // R2 clean reads
    for (int i = 0; i < 12; i++) begin
      for (int k = 0; k < BYTES; k++) fl[k] = '0;
      do_read($urandom, fl, i[0], 1'b1, "R2 clean");
    end

    // R3 single flips, every position on a rotating lane
    for (int i = 0; i < 40; i++) begin
      for (int k = 0; k < BYTES; k++) fl[k] = '0;
      b = i % BYTES;
      p0 = (i < 13) ? i : $urandom_range(12, 0);
      fl[b][p0] = 1'b1;
      do_read($urandom, fl, i[1], 1'b1, "R3 single");
      if (i % 7 == 6) evt_write(4'h0);
    end

    // R4 double flips
    for (int i = 0; i < 30; i++) begin
      for (int k = 0; k < BYTES; k++) fl[k] = '0;
      b = $urandom_range(BYTES - 1, 0);
      p0 = $urandom_range(12, 0);
      p1 = (p0 + 1 + $urandom_range(11, 0)) % 13;
      fl[b][p0] = 1'b1; fl[b][p1] = 1'b1;
      do_read($urandom, fl, i[0], 1'b1, "R4 double");
      if (i % 5 == 4) evt_write(4'h0);
    end

    // R6 mixed lanes in one read: single on byte 0, double on byte 2
    evt_write(4'h0);
    for (int k = 0; k < BYTES; k++) fl[k] = '0;
    fl[0] = 13'h0004; fl[2] = 13'h0101;
    do_read(32'hA5C3_0F96, fl, 1'b1, 1'b1, "R6 two lanes");
    check("R6 both data classes", evt_q, 4'b1100);

    // R6 invalid read sets nothing
    for (int k = 0; k < BYTES; k++) fl[k] = '0;
    fl[1] = 13'h0003;
    do_read(32'h1234_5678, fl, 1'b0, 1'b0, "R6 invalid read");
    check("R6 invalid read no instr flag", evt_q[1:0], 2'b00);

    // R7 nonzero write ignored, then clear
    evt_write(4'hF);
    evt_write(4'h5);
    evt_write(4'h0);
    check("R7 cleared", evt_q, 4'h0);

    // R8 clear collides with a single error read
    d = 32'hDEAD_BEEF;
    exp_q = 4'h0;
    for (int k = 0; k < BYTES; k++) fl[k] = '0;
    fl[0] = 13'h0004; fl[3] = 13'h0101;
    do_read(d, fl, 1'b1, 1'b1, "R8 setup");
    for (int k = 0; k < BYTES; k++) fl[k] = '0;
    fl[3] = 13'h0010;
    @(negedge clk);
    rd_valid = 1'b1; rd_src = 1'b0;
    rd_data = d ^ 32'h1000_0000; rd_check = ref_word(d);
    evt_we = 1'b1; evt_wdata = 4'h0;
    @(negedge clk);
    rd_valid = 1'b0; evt_we = 1'b0;
    #1;
    exp_q = 4'b0001;
    check("R8 event beats clear", evt_q, exp_q);
    check("R9 irq after collision", irq, 1'b1);
    evt_write(4'h0);
    check("R9 irq low", irq, 1'b0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule